// File: doc/BRIEF.md
# Serial-Audio to Biphase-Mark Transmitter

This block takes two-channel audio over a three-wire serial link (bit clock, frame sync, data) and sends it out on one line as a biphase-mark coded stream built from 32-slot subframes. The three serial wires are brought into the system clock domain, and the block acts on every rising edge of the bit clock. One of three input framings is chosen on `fmt_sel`. One of four sample widths is chosen on `width_sel`. Each finished word goes into a left or right holding register.

The output side runs on its own count of system clocks. Every half-cell lasts `HALF_DIV` clock cycles. At the start of each left subframe the encoder copies both holding registers into a working pair, so the two channels of one frame always come from the same stereo pair. A subframe holds four slots of preamble, a 24-bit audio field sent LSB first, a validity bit, a user bit, a channel-status bit and an even-parity bit. Frames are counted in 192-frame blocks, and the channel-status bit is taken from the `CSTAT` parameter.

The serial clock and frame sync must each hold a level for at least two system clock cycles. The rate of the output frames is set by `HALF_DIV`, and the user matches it to the input frame rate.

Top module: `spdif_tx_core`

## Requirements
- R1: While `rst` is high, `spdif_out` is 0. After reset the first subframe sent is a left subframe with the block-start preamble.
- R2: With `fmt_sel`=2'b00 (left-justified), the channel is left while the frame sync is 1 and right while it is 0. The sample MSB is the first bit sampled at or after the frame-sync change.
- R3: With `fmt_sel`=2'b01 (I2S), the channel is left while the frame sync is 0. The sample MSB is sampled one bit-clock rising edge after the frame-sync change.
- R4: With `fmt_sel`=2'b10 (right-justified), the channel is left while the frame sync is 1. The sample LSB is the last bit sampled before the frame-sync change.
- R5: `width_sel` 2'b00/01/10/11 selects 16/18/20/24-bit samples. The sample is left-aligned in the 24-bit audio field with zeros in the unused low bits. Slots 4..27 carry that field LSB first.
- R6: Every half-cell lasts `HALF_DIV` clocks and the line changes only at half-cell boundaries. From slot 4 onward the line toggles at every cell start, and it toggles again mid-cell for a 1.
- R7: Slots 0..3 carry a preamble written as 8 half-cells, where 1 means the inverse of the line level before the preamble. The block-start pattern is 11101000, the left pattern is 11100010 and the right pattern is 11100100.
- R8: The block-start preamble replaces the left preamble once every 192 frames.
- R9: The validity bit (slot 28) and the user bit (slot 29) are 0. The channel-status bit (slot 30) in frame f of a block is `CSTAT[f]` for f<32 and 0 otherwise, and it is the same in both subframes of a frame.
- R10: The parity bit (slot 31) makes the number of ones in slots 4..31 even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Serial framing: 00 left-justified, 01 I2S, 10 right-justified |
| width_sel | input | 2 | Sample width: 00=16, 01=18, 10=20, 11=24 bits |
| ser_bclk | input | 1 | Serial bit clock, sampled by `clk` |
| ser_fsync | input | 1 | Serial frame sync (channel select) |
| ser_data | input | 1 | Serial audio data, MSB first |
| spdif_out | output | 1 | Registered biphase-mark output line |

## Verification
A serial word reaches its holding register three to four clocks after the bit-clock edge that completes it. It enters the output at the next left subframe, which can be up to a full output frame later. For this reason the bench changes the configuration and then waits three full serial frames before decoding. The output is registered, so a half-cell value appears one clock after its internal tick. The bench takes no absolute clock count from this. It locks onto the two back-to-back three-half-cell runs that open a left preamble, samples each half-cell `HALF_DIV` clocks apart at falling clock edges, and decodes whole subframes. Block-start spacing and channel-status bits are checked over 193 consecutive frames, counted from the first block-start preamble found.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int AUDIO_W = 24;
  localparam int SLOTS   = 32;
  localparam int FRAMES  = 192;
  localparam int FR_W    = $clog2(FRAMES);
  localparam int PAY_W   = SLOTS - 4;

  localparam logic [1:0] FMT_LJ  = 2'b00;
  localparam logic [1:0] FMT_I2S = 2'b01;
  localparam logic [1:0] FMT_RJ  = 2'b10;

  // Preamble half-cell patterns, relative to an initial level of 0
  localparam logic [7:0] PRE_BLOCK = 8'b11101000;
  localparam logic [7:0] PRE_LEFT  = 8'b11100010;
  localparam logic [7:0] PRE_RIGHT = 8'b11100100;

  function automatic logic [4:0] width_of(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd16;
      2'b01:   return 5'd18;
      2'b10:   return 5'd20;
      default: return 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/spdif_ser_in.sv
module spdif_ser_in
  import spdif_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         fmt,
  input  logic [1:0]         wcode,
  input  logic               bclk,
  input  logic               fsync,
  input  logic               sdata,
  output logic [AUDIO_W-1:0] word_o,
  output logic               left_stb,
  output logic               right_stb
);
  logic [2:0]         bclk_s;
  logic [1:0]         fs_s;
  logic [1:0]         sd_s;
  logic               lr_prev;
  logic [4:0]         idx_q;
  logic [AUDIO_W-1:0] sr_q;

  logic               rise, lr, changed, is_left, done, done_left;
  logic [4:0]         cur_idx, wbits, shamt;
  logic [AUDIO_W-1:0] nxt_sr, aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_s <= '0;
      fs_s   <= '0;
      sd_s   <= '0;
    end else begin
      bclk_s <= {bclk_s[1:0], bclk};
      fs_s   <= {fs_s[0], fsync};
      sd_s   <= {sd_s[0], sdata};
    end
  end

  always_comb begin
    rise    = bclk_s[1] & ~bclk_s[2];
    lr      = fs_s[1];
    changed = (lr != lr_prev);
    cur_idx = changed ? 5'd0 : ((idx_q == 5'd31) ? 5'd31 : idx_q + 5'd1);
    nxt_sr  = {sr_q[AUDIO_W-2:0], sd_s[1]};
    is_left = (fmt == FMT_I2S) ? ~lr : lr;
    wbits   = width_of(wcode);
    shamt   = 5'd24 - wbits;
    done      = 1'b0;
    done_left = is_left;
    aligned   = nxt_sr << shamt;
    case (fmt)
      FMT_I2S: done = (cur_idx == wbits);
      FMT_RJ: begin
        done      = changed;
        done_left = ~is_left;
        aligned   = sr_q << shamt;
      end
      default: done = (cur_idx == wbits - 5'd1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev   <= 1'b0;
      idx_q     <= 5'd31;
      sr_q      <= '0;
      word_o    <= '0;
      left_stb  <= 1'b0;
      right_stb <= 1'b0;
    end else begin
      left_stb  <= 1'b0;
      right_stb <= 1'b0;
      if (rise) begin
        lr_prev <= lr;
        idx_q   <= cur_idx;
        sr_q    <= nxt_sr;
        if (done) begin
          word_o    <= aligned;
          left_stb  <= done_left;
          right_stb <= ~done_left;
        end
      end
    end
  end
endmodule

// File: rtl/spdif_subframe.sv
module spdif_subframe
  import spdif_tx_pkg::*;
(
  input  logic [AUDIO_W-1:0] smp,
  input  logic               cbit,
  input  logic               is_right,
  input  logic               is_block,
  output logic [PAY_W-1:0]   payload,
  output logic [7:0]         pre_pat
);
  logic [PAY_W-2:0] body;

  always_comb begin
    body    = {cbit, 1'b0, 1'b0, smp};
    payload = {^body, body};
    if (is_right)      pre_pat = PRE_RIGHT;
    else if (is_block) pre_pat = PRE_BLOCK;
    else               pre_pat = PRE_LEFT;
  end
endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
  import spdif_tx_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AUDIO_W-1:0] hold_l,
  input  logic [AUDIO_W-1:0] hold_r,
  input  logic [PAY_W-1:0]   payload,
  input  logic [7:0]         pre_pat,
  output logic [AUDIO_W-1:0] cur_smp,
  output logic               nxt_right,
  output logic               nxt_block,
  output logic [FR_W-1:0]    nxt_frame,
  output logic               tick_o,
  output logic               half_o,
  output logic [4:0]         slot_o,
  output logic [FR_W-1:0]    frame_o,
  output logic               line_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST   = DIV_W'(HALF_DIV - 1);
  localparam logic [FR_W-1:0]  FRAME_LAST = FR_W'(FRAMES - 1);

  logic [DIV_W-1:0]   div_q;
  logic               half_q, sub_q, base_q, line_q;
  logic [4:0]         slot_q;
  logic [FR_W-1:0]    frame_q;
  logic [AUDIO_W-1:0] pair_l, pair_r;

  logic            tick, n_half, n_sub, n_base, n_line;
  logic [4:0]      n_slot, pidx;
  logic [FR_W-1:0] n_frame;
  logic [2:0]      pi;

  always_comb begin
    tick    = (div_q == DIV_LAST);
    n_half  = ~half_q;
    n_slot  = slot_q;
    n_sub   = sub_q;
    n_frame = frame_q;
    if (half_q) begin
      n_slot = slot_q + 5'd1;
      if (slot_q == 5'd31) begin
        n_sub = ~sub_q;
        if (sub_q) n_frame = (frame_q == FRAME_LAST) ? '0 : frame_q + 1'b1;
      end
    end
    pi     = {n_slot[1:0], n_half};
    pidx   = n_slot - 5'd4;
    n_base = (n_slot == 5'd0 && !n_half) ? line_q : base_q;
    if (n_slot < 5'd4)  n_line = pre_pat[3'd7 - pi] ^ n_base;
    else if (!n_half)   n_line = ~line_q;
    else                n_line = line_q ^ payload[pidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      half_q  <= 1'b1;
      slot_q  <= 5'd31;
      sub_q   <= 1'b1;
      frame_q <= FRAME_LAST;
      base_q  <= 1'b0;
      line_q  <= 1'b0;
      pair_l  <= '0;
      pair_r  <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        half_q  <= n_half;
        slot_q  <= n_slot;
        sub_q   <= n_sub;
        frame_q <= n_frame;
        base_q  <= n_base;
        line_q  <= n_line;
        if (n_slot == 5'd0 && !n_half && !n_sub) begin
          pair_l <= hold_l;
          pair_r <= hold_r;
        end
      end
    end
  end

  assign cur_smp   = n_sub ? pair_r : pair_l;
  assign nxt_right = n_sub;
  assign nxt_block = !n_sub && (n_frame == '0);
  assign nxt_frame = n_frame;
  assign tick_o    = tick;
  assign half_o    = half_q;
  assign slot_o    = slot_q;
  assign frame_o   = frame_q;
  assign line_o    = line_q;
endmodule

// File: rtl/spdif_tx_core.sv
module spdif_tx_core
  import spdif_tx_pkg::*;
#(
  parameter int          HALF_DIV = 2,
  parameter logic [31:0] CSTAT    = 32'h0200_0104
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] fmt_sel,
  input  logic [1:0] width_sel,
  input  logic       ser_bclk,
  input  logic       ser_fsync,
  input  logic       ser_data,
  output logic       spdif_out
);
  logic [AUDIO_W-1:0] word, hold_l, hold_r, cur_smp;
  logic               wl_stb, wr_stb;
  logic [PAY_W-1:0]   payload;
  logic [7:0]         pre_pat;
  logic               nxt_right, nxt_block, cbit;
  logic [FR_W-1:0]    nxt_frame, enc_frame;
  logic               enc_tick, enc_half;
  logic [4:0]         enc_slot;

  spdif_ser_in u_in (
    .clk(clk), .rst(rst), .fmt(fmt_sel), .wcode(width_sel),
    .bclk(ser_bclk), .fsync(ser_fsync), .sdata(ser_data),
    .word_o(word), .left_stb(wl_stb), .right_stb(wr_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l <= '0;
      hold_r <= '0;
    end else begin
      if (wl_stb) hold_l <= word;
      if (wr_stb) hold_r <= word;
    end
  end

  assign cbit = (nxt_frame < FR_W'(32)) ? CSTAT[nxt_frame[4:0]] : 1'b0;

  spdif_subframe u_sf (
    .smp(cur_smp), .cbit(cbit), .is_right(nxt_right), .is_block(nxt_block),
    .payload(payload), .pre_pat(pre_pat)
  );

  spdif_bmc_enc #(.HALF_DIV(HALF_DIV)) u_enc (
    .clk(clk), .rst(rst), .hold_l(hold_l), .hold_r(hold_r),
    .payload(payload), .pre_pat(pre_pat), .cur_smp(cur_smp),
    .nxt_right(nxt_right), .nxt_block(nxt_block), .nxt_frame(nxt_frame),
    .tick_o(enc_tick), .half_o(enc_half), .slot_o(enc_slot),
    .frame_o(enc_frame), .line_o(spdif_out)
  );
endmodule

// File: rtl/spdif_tx_checker.sv
module spdif_tx_checker (
  input logic       clk,
  input logic       rst,
  input logic       line,
  input logic       tick,
  input logic       half,
  input logic [4:0] slot,
  input logic [7:0] frame,
  input logic       stb_l,
  input logic       stb_r
);
  // R6: the line moves only on a half-cell tick
  a_r6_hold_between_halves: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(line));
  // R6: every cell start from slot 4 on (and the preamble entry) changes the line
  a_r6_toggle_at_cell_start: assert property (@(posedge clk) disable iff (rst)
    (tick && half && slot >= 5'd3) |=> (line != $past(line)));
  // R7: the first three preamble half-cells share one level
  a_r7_preamble_violation: assert property (@(posedge clk) disable iff (rst)
    (tick && slot == 5'd0) |=> $stable(line));
  // R8: frame index stays inside the block
  a_r8_frame_bound: assert property (@(posedge clk) disable iff (rst)
    frame < 8'd192);
  // R2: a completed serial word belongs to one channel only
  a_r2_single_word_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb_l, stb_r}));
endmodule

bind spdif_tx_core spdif_tx_checker u_chk (
  .clk(clk), .rst(rst), .line(spdif_out), .tick(enc_tick), .half(enc_half),
  .slot(enc_slot), .frame(enc_frame), .stb_l(wl_stb), .stb_r(wr_stb)
);

// File: tb/spdif_tx_core_bench.sv
module spdif_tx_core_bench;
  localparam int          HD = 2;
  localparam logic [31:0] CS = 32'h8000_0105;
  localparam logic [7:0]  P_B = 8'b11101000;
  localparam logic [7:0]  P_M = 8'b11100010;
  localparam logic [7:0]  P_W = 8'b11100100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] fmt_sel = 2'b00;
  logic [1:0] width_sel = 2'b11;
  logic ser_bclk = 1'b0, ser_fsync = 1'b0, ser_data = 1'b0;
  logic spdif_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  int wbits = 24;
  logic [23:0] smp_l = '0, smp_r = '0;
  logic h [64];
  logic [27:0] bits;
  logic [7:0]  pre_seen;

  always #10 clk = ~clk;

  spdif_tx_core #(.HALF_DIV(HD), .CSTAT(CS)) u_spdif_tx_core (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .width_sel(width_sel),
    .ser_bclk(ser_bclk), .ser_fsync(ser_fsync), .ser_data(ser_data),
    .spdif_out(spdif_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Serial source: 32 bit-clock periods per channel, 4 clocks per bit
  initial begin
    forever begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int b = 0; b < 32; b++) begin
          logic [23:0] s;
          logic fs, d;
          s = (ch == 0) ? smp_l : smp_r;
          d = 1'b0;
          case (fmt_sel)
            2'b01: begin
              fs = (ch == 1);
              if (b >= 1 && b <= wbits) d = s[wbits - b];
            end
            2'b10: begin
              fs = (ch == 0);
              if (b >= 32 - wbits) d = s[31 - b];
            end
            default: begin
              fs = (ch == 0);
              if (b < wbits) d = s[wbits - 1 - b];
            end
          endcase
          @(negedge clk);
          ser_bclk = 1'b0; ser_fsync = fs; ser_data = d;
          @(negedge clk);
          @(negedge clk);
          ser_bclk = 1'b1;
          @(negedge clk);
        end
      end
    end
  end

  // Lock onto a left (non-block) preamble: two back-to-back 3-half-cell runs
  task automatic sync_left();
    int run, p1, p2;
    logic lvl;
    run = 1; p1 = 0; p2 = 0;
    @(negedge clk);
    lvl = spdif_out;
    forever begin
      @(negedge clk);
      if (spdif_out === lvl) run++;
      else begin
        p2 = p1; p1 = run; run = 1; lvl = spdif_out;
        if (p1 == 3 * HD && p2 == 3 * HD) return;
      end
    end
  endtask

  task automatic read_halves(input int from);
    for (int k = from; k < 64; k++) begin
      h[k] = spdif_out;
      repeat (HD) @(negedge clk);
    end
  endtask

  // Decode the subframe held in h[] and check it
  task automatic check_sub(input bit chk_pre, input logic [7:0] exp_pre,
                           input logic [23:0] exp_smp, input bit chk_c, input logic exp_c);
    bit edges_ok;
    edges_ok = 1;
    for (int k = 0; k < 8; k++) pre_seen[7 - k] = h[k] ^ ~h[0];
    for (int k = 0; k < 28; k++) begin
      bits[k] = h[8 + 2 * k] ^ h[9 + 2 * k];
      if (h[8 + 2 * k] == h[7 + 2 * k]) edges_ok = 0;
    end
    check(edges_ok, "R6 cell-start transitions", {31'd0, edges_ok}, 32'd1);
    if (chk_pre) check(pre_seen == exp_pre, "R7 preamble", {24'd0, pre_seen}, {24'd0, exp_pre});
    check(bits[23:0] == exp_smp, "R5 audio field", {8'd0, bits[23:0]}, {8'd0, exp_smp});
    check(bits[25:24] == 2'b00, "R9 validity/user", {30'd0, bits[25:24]}, 32'd0);
    if (chk_c) check(bits[26] == exp_c, "R9 channel status", {31'd0, bits[26]}, {31'd0, exp_c});
    check(^bits == 1'b0, "R10 even parity", {4'd0, bits}, 32'd0);
  endtask

  function automatic logic [23:0] field(input logic [23:0] v, input int w);
    return v << (24 - w);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(spdif_out == 1'b0, "R1 line low in reset", {31'd0, spdif_out}, 32'd0);
    rst = 1'b0;
    // R1: first subframe begins with the block-start preamble
    begin
      logic first;
      first = 0;
      while (!first) begin @(negedge clk); first = spdif_out; end
      for (int k = 0; k < 64; k++) begin
        h[k] = spdif_out;
        repeat (HD) @(negedge clk);
      end
      for (int k = 0; k < 8; k++) pre_seen[7 - k] = h[k];
      check(pre_seen == P_B, "R1 first preamble is block start", {24'd0, pre_seen}, {24'd0, P_B});
    end

    // R2/R3/R4/R5: sweep every framing and width
    for (int f = 0; f < 3; f++) begin
      for (int w = 0; w < 4; w++) begin
        logic [23:0] mask, vl, vr;
        fmt_sel = f[1:0];
        width_sel = w[1:0];
        wbits = (w == 0) ? 16 : (w == 1) ? 18 : (w == 2) ? 20 : 24;
        mask = 24'((32'd1 << wbits) - 1);
        vl = (24'h9A5C3E + 24'(f * 4 + w) * 24'h011107) & mask;
        vr = (~vl) & mask;
        vl[wbits - 1] = 1'b1;
        smp_l = vl; smp_r = vr;
        repeat (3 * 256) @(negedge clk);
        sync_left();
        read_halves(6);
        // R2 R3 R4: left channel assignment and bit alignment per framing
        check_sub(0, P_M, field(vl, wbits), 0, 1'b0);
        read_halves(0);
        check_sub(1, P_W, field(vr, wbits), 0, 1'b0);
        if (f == 0) check(bits[23:0] == field(vr, wbits), "R2 left-justified right word", {8'd0, bits[23:0]}, {8'd0, field(vr, wbits)});
        if (f == 1) check(bits[23:0] == field(vr, wbits), "R3 I2S right word", {8'd0, bits[23:0]}, {8'd0, field(vr, wbits)});
        if (f == 2) check(bits[23:0] == field(vr, wbits), "R4 right-justified right word", {8'd0, bits[23:0]}, {8'd0, field(vr, wbits)});
      end
    end

    // R8/R9: block spacing and channel status over a full block
    fmt_sel = 2'b00; width_sel = 2'b11; wbits = 24;
    smp_l = 24'hC0FFEE; smp_r = 24'h135799;
    repeat (3 * 256) @(negedge clk);
    sync_left();
    read_halves(6);
    read_halves(0);
    begin
      bit found;
      found = 0;
      for (int n = 0; n < 193 && !found; n++) begin
        read_halves(0);
        for (int k = 0; k < 8; k++) pre_seen[7 - k] = h[k] ^ ~h[0];
        if (pre_seen == P_B) found = 1;
        else read_halves(0);
      end
      check(found, "R8 block start seen", {31'd0, found}, 32'd1);
      for (int idx = 0; idx <= 192; idx++) begin
        logic expc;
        int fi;
        fi = idx % 192;
        expc = (fi < 32) ? CS[fi] : 1'b0;
        if (idx > 0) read_halves(0);
        check_sub(1, (fi == 0) ? P_B : P_M, 24'hC0FFEE, 1, expc);
        if (fi == 0 || fi == 1) check(pre_seen == ((fi == 0) ? P_B : P_M), "R8 block preamble spacing", {24'd0, pre_seen}, {24'd0, (fi == 0) ? P_B : P_M});
        read_halves(0);
        check_sub(1, P_W, 24'h135799, 1, expc);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule